// File: doc/BRIEF.md
# Flash Program/Erase Error Sequencer

This block sits between the request path and the flash array of a non-volatile memory controller. It takes a program-word, program-row or erase request together with the target address and a set of qualifying conditions: the ECC mode, privilege, the write-protect lookup, and whether the brown-out detector is ready. It screens the request against these conditions in a fixed priority order. A request that fails screening is turned away at once. It never raises `busy`, and it leaves a flag pattern that names the reason.

An accepted row request first waits in an arming phase until the row buffer reports it is full. Word and erase requests go straight into the run phase. In the run phase a cycle counter stands in for the array timing: every word takes a programmable number of cycles, and `wrStrobe` pulses once per committed word. Asynchronous hazards are handled in two ways. A hazard that arrives before the run phase rejects the request. The same hazard arriving during the run phase aborts it, and the flags then differ. The hazards are thermal, supply/reset, tamper, row-buffer underrun and bus-host error.

All flags stay set until a write-one-to-clear mask is applied.

Top module: `flash_err_seq`

## Requirements
- R1: When `busy` falls, `done` is 1 in that same cycle. The only exception is an abort caused by `rstEvt`, which drops `busy` without setting `done`.
- R2: `rstEvt` while idle or arming sets only the reset flag (errFlags bit 1), with `done` untouched and no run. `rstEvt` in the run phase sets the reset flag and the write flag (bit 0) and aborts without `done`.
- R3: A request issued while `borReady` is 0 sets the reset flag (bit 1) and `done`, and never raises `busy`.
- R4: `hotEvt` at request time or during arming sets the thermal flag (bit 2) and `done`, and no word is written.
- R5: Command codes other than 1 (word), 2 (row) and 3 (erase) set the op flag (bit 5) and `done`, without starting.
- R6: An address at or above FLASH_WORDS (40960 by default), or `privOk` = 0, sets the config flag (bit 4) and `done`, without starting.
- R7: A word request (code 1) while `eccStrict` is 1 sets the config and op flags (bits 4 and 5) and `done`, without starting. Row requests are not affected by `eccStrict`.
- R8: A request that hits write protection (`wpHit`) sets the protect flag (bit 8) and `done`. When the protection belongs to a foreign security domain (`wpForeign`), the security flag (bit 3) is also set. The operation does not start in either case.
- R9: When several screening faults coincide, only the first one in this order is reported: supply/reset event, brown-out not ready, thermal, unknown code, address/privilege, ECC conflict, write protect.
- R10: `busErr` during row arming sets the bus and buffer flags (bits 7 and 6) and `done`, and no word is written.
- R11: During a row run, `fifoUnder` sets the write and buffer flags (bits 0 and 6) and `done`. `busErr` additionally sets the bus flag (bit 7). No further `wrStrobe` follows either abort. Both inputs are ignored for word and erase runs.
- R12: `tamperEvt` in the run phase sets the write and security flags (bits 0 and 3) and `done`, and aborts the run.
- R13: A clean run lasts words × `cpwIn` cycles, where a row has ROW_WORDS (4) words and word and erase requests have 1 word. A `cpwIn` of 0 counts as 1. `wrStrobe` pulses once per word.
- R14: Flags persist until cleared by `clrErr`/`clrDone`. When a set and a clear of the same flag happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Request strobe, sampled while idle |
| cmdOp | input | 3 | Command code (1 word, 2 row, 3 erase) |
| cmdAddr | input | ADDR_W | Target word address |
| eccStrict | input | 1 | ECC write-with-read mode active |
| privOk | input | 1 | Privilege setting allowed |
| wpHit | input | 1 | Target is write protected |
| wpForeign | input | 1 | Protection owned by another security domain |
| borReady | input | 1 | Brown-out detector ready |
| hotEvt | input | 1 | High-temperature event |
| rstEvt | input | 1 | Reset or low-voltage event |
| tamperEvt | input | 1 | Security/tamper preemption |
| fifoUnder | input | 1 | Row buffer underrun |
| busErr | input | 1 | Bus-host error on row data fetch |
| fifoReady | input | 1 | Row buffer filled |
| cpwIn | input | CPW_W | Cycles per word |
| clrDone | input | 1 | Write-one clear of done |
| clrErr | input | 9 | Write-one clear mask for error flags |
| busy | output | 1 | Request in arming or run phase |
| done | output | 1 | Sticky completion flag |
| errFlags | output | 9 | Sticky error flags |
| wrStrobe | output | 1 | One word committed this cycle |

## Verification
A screening fault that is checked in the wrong priority position shows up one cycle after the request, as the wrong flag pattern in `errFlags`. Because the losing faults must leave no trace, the flag vector gives an exact signature. A run-phase counter that is corrupted or loaded wrongly appears as a `busy` window of the wrong length and as the wrong number of `wrStrobe` pulses. A controller stuck in the wrong phase shows when an injected hazard produces the reject pattern instead of the abort pattern, or the reverse, on the edge after the hazard.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int ERR_W = 9;

  localparam int E_WR   = 0;
  localparam int E_RST  = 1;
  localparam int E_HOT  = 2;
  localparam int E_SEC  = 3;
  localparam int E_CFG  = 4;
  localparam int E_OP   = 5;
  localparam int E_FIFO = 6;
  localparam int E_BUS  = 7;
  localparam int E_WP   = 8;

  localparam logic [2:0] OP_WORD  = 3'd1;
  localparam logic [2:0] OP_ROW   = 3'd2;
  localparam logic [2:0] OP_ERASE = 3'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RUN  = 2'd2
  } fesState_t;

  typedef struct packed {
    logic             setDone;
    logic [ERR_W-1:0] setErr;
    logic             cntLoad;
    logic             cntStep;
    logic             loadRow;
  } fesStrobe_t;
endpackage

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int FLASH_WORDS = 40960
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              eccStrict,
  input  logic              privOk,
  input  logic              wpHit,
  input  logic              wpForeign,
  input  logic              borReady,
  input  logic              hotEvt,
  input  logic              rstEvt,
  input  logic              tamperEvt,
  input  logic              fifoUnder,
  input  logic              busErr,
  input  logic              fifoReady,
  input  logic              wordEnd,
  input  logic              lastWord,
  output fesStrobe_t        strb,
  output logic              busy,
  output logic              runPhase,
  output logic              wrStrobe
);
  localparam logic [ADDR_W:0] ADDR_LIMIT = (ADDR_W + 1)'(FLASH_WORDS);

  fesState_t state, nxt;
  logic      rowQ, rowD;
  logic      opKnown, addrBad, abortRun;

  assign opKnown  = (cmdOp == OP_WORD) || (cmdOp == OP_ROW) || (cmdOp == OP_ERASE);
  assign addrBad  = ({1'b0, cmdAddr} >= ADDR_LIMIT);
  assign abortRun = rstEvt || tamperEvt || (rowQ && (busErr || fifoUnder));

  always_comb begin
    nxt  = state;
    rowD = rowQ;
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        if (rstEvt) begin
          strb.setErr[E_RST] = 1'b1;
        end else if (cmdValid) begin
          if (!borReady) begin
            strb.setErr[E_RST] = 1'b1;
            strb.setDone       = 1'b1;
          end else if (hotEvt) begin
            strb.setErr[E_HOT] = 1'b1;
            strb.setDone       = 1'b1;
          end else if (!opKnown) begin
            strb.setErr[E_OP] = 1'b1;
            strb.setDone      = 1'b1;
          end else if (addrBad || !privOk) begin
            strb.setErr[E_CFG] = 1'b1;
            strb.setDone       = 1'b1;
          end else if ((cmdOp == OP_WORD) && eccStrict) begin
            strb.setErr[E_CFG] = 1'b1;
            strb.setErr[E_OP]  = 1'b1;
            strb.setDone       = 1'b1;
          end else if (wpHit) begin
            strb.setErr[E_WP]  = 1'b1;
            strb.setErr[E_SEC] = wpForeign;
            strb.setDone       = 1'b1;
          end else if (cmdOp == OP_ROW) begin
            rowD = 1'b1;
            nxt  = ST_FILL;
          end else begin
            rowD         = 1'b0;
            strb.cntLoad = 1'b1;
            nxt          = ST_RUN;
          end
        end
      end
      ST_FILL: begin
        if (rstEvt) begin
          strb.setErr[E_RST] = 1'b1;
          nxt                = ST_IDLE;
        end else if (hotEvt) begin
          strb.setErr[E_HOT] = 1'b1;
          strb.setDone       = 1'b1;
          nxt                = ST_IDLE;
        end else if (busErr) begin
          strb.setErr[E_BUS]  = 1'b1;
          strb.setErr[E_FIFO] = 1'b1;
          strb.setDone        = 1'b1;
          nxt                 = ST_IDLE;
        end else if (fifoReady) begin
          strb.cntLoad = 1'b1;
          strb.loadRow = 1'b1;
          nxt          = ST_RUN;
        end
      end
      ST_RUN: begin
        if (rstEvt) begin
          strb.setErr[E_RST] = 1'b1;
          strb.setErr[E_WR]  = 1'b1;
          nxt                = ST_IDLE;
        end else if (tamperEvt) begin
          strb.setErr[E_WR]  = 1'b1;
          strb.setErr[E_SEC] = 1'b1;
          strb.setDone       = 1'b1;
          nxt                = ST_IDLE;
        end else if (rowQ && busErr) begin
          strb.setErr[E_WR]   = 1'b1;
          strb.setErr[E_BUS]  = 1'b1;
          strb.setErr[E_FIFO] = 1'b1;
          strb.setDone        = 1'b1;
          nxt                 = ST_IDLE;
        end else if (rowQ && fifoUnder) begin
          strb.setErr[E_WR]   = 1'b1;
          strb.setErr[E_FIFO] = 1'b1;
          strb.setDone        = 1'b1;
          nxt                 = ST_IDLE;
        end else begin
          strb.cntStep = 1'b1;
          if (wordEnd && lastWord) begin
            strb.setDone = 1'b1;
            nxt          = ST_IDLE;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rowQ  <= 1'b0;
    end else begin
      state <= nxt;
      rowQ  <= rowD;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign runPhase = (state == ST_RUN);
  assign wrStrobe = runPhase && wordEnd && !abortRun;
endmodule

// File: rtl/fes_dpath.sv
module fes_dpath
  import fes_pkg::*;
#(
  parameter int ROW_WORDS = 4,
  parameter int CPW_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fesStrobe_t       strb,
  input  logic [CPW_W-1:0] cpwIn,
  input  logic             clrDone,
  input  logic [ERR_W-1:0] clrErr,
  output logic             done,
  output logic [ERR_W-1:0] errFlags,
  output logic             wordEnd,
  output logic             lastWord
);
  localparam int              WC_W    = $clog2(ROW_WORDS + 1);
  localparam logic [WC_W-1:0] ROW_CNT = WC_W'(ROW_WORDS);

  logic [CPW_W-1:0] cycQ, cpwQ, cpwEff;
  logic [WC_W-1:0]  wordQ, wordsQ;
  logic             doneQ;

  assign cpwEff   = (cpwIn == '0) ? CPW_W'(1) : cpwIn;
  assign wordEnd  = (cycQ == cpwQ - CPW_W'(1));
  assign lastWord = (wordQ == wordsQ - WC_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycQ   <= '0;
      cpwQ   <= CPW_W'(1);
      wordQ  <= '0;
      wordsQ <= WC_W'(1);
    end else if (strb.cntLoad) begin
      cycQ   <= '0;
      cpwQ   <= cpwEff;
      wordQ  <= '0;
      wordsQ <= strb.loadRow ? ROW_CNT : WC_W'(1);
    end else if (strb.cntStep) begin
      if (wordEnd) begin
        cycQ  <= '0;
        wordQ <= wordQ + WC_W'(1);
      end else begin
        cycQ <= cycQ + CPW_W'(1);
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < ERR_W; gi++) begin : g_flag
      logic flagQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) flagQ <= 1'b0;
        else       flagQ <= (flagQ && !clrErr[gi]) || strb.setErr[gi];
      end
      assign errFlags[gi] = flagQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= (doneQ && !clrDone) || strb.setDone;
  end
  assign done = doneQ;
endmodule

// File: rtl/flash_err_seq.sv
module flash_err_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int FLASH_WORDS = 40960,
  parameter int ROW_WORDS   = 4,
  parameter int CPW_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              eccStrict,
  input  logic              privOk,
  input  logic              wpHit,
  input  logic              wpForeign,
  input  logic              borReady,
  input  logic              hotEvt,
  input  logic              rstEvt,
  input  logic              tamperEvt,
  input  logic              fifoUnder,
  input  logic              busErr,
  input  logic              fifoReady,
  input  logic [CPW_W-1:0]  cpwIn,
  input  logic              clrDone,
  input  logic [ERR_W-1:0]  clrErr,
  output logic              busy,
  output logic              done,
  output logic [ERR_W-1:0]  errFlags,
  output logic              wrStrobe
);
  fesStrobe_t strb;
  logic       wordEnd, lastWord, runPhase;

  fes_ctrl #(.ADDR_W(ADDR_W), .FLASH_WORDS(FLASH_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .eccStrict(eccStrict), .privOk(privOk), .wpHit(wpHit), .wpForeign(wpForeign),
    .borReady(borReady), .hotEvt(hotEvt), .rstEvt(rstEvt), .tamperEvt(tamperEvt),
    .fifoUnder(fifoUnder), .busErr(busErr), .fifoReady(fifoReady),
    .wordEnd(wordEnd), .lastWord(lastWord), .strb(strb), .busy(busy),
    .runPhase(runPhase), .wrStrobe(wrStrobe)
  );

  fes_dpath #(.ROW_WORDS(ROW_WORDS), .CPW_W(CPW_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cpwIn(cpwIn), .clrDone(clrDone),
    .clrErr(clrErr), .done(done), .errFlags(errFlags), .wordEnd(wordEnd),
    .lastWord(lastWord)
  );
endmodule

// File: rtl/flash_err_seq_chk.sv
module flash_err_seq_chk
  import fes_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [2:0]       cmdOp,
  input logic             borReady,
  input logic             hotEvt,
  input logic             rstEvt,
  input logic             tamperEvt,
  input logic             clrDone,
  input logic [ERR_W-1:0] clrErr,
  input logic             busy,
  input logic             done,
  input logic [ERR_W-1:0] errFlags,
  input logic             wrStrobe,
  input logic             runPhase
);
  logic opReserved;
  assign opReserved = (cmdOp == 3'd0) || (cmdOp > 3'd3);

  AST_BUSY_DONE_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) && !$past(rstEvt) |-> done); // R1

  AST_RST_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    runPhase && rstEvt |=> !busy && errFlags[E_WR] && errFlags[E_RST]); // R2

  AST_BOR_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    !busy && cmdValid && !rstEvt && !borReady |=> !busy && done && errFlags[E_RST]); // R3

  AST_OP_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    !busy && cmdValid && !rstEvt && borReady && !hotEvt && opReserved
    |=> !busy && done && errFlags[E_OP]); // R5

  AST_TAMPER_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    runPhase && tamperEvt && !rstEvt |=> !busy && done && errFlags[E_WR] && errFlags[E_SEC]); // R12

  AST_STROBE_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> runPhase && busy); // R13

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> $past(clrDone)); // R14

  genvar gi;
  generate
    for (gi = 0; gi < ERR_W; gi++) begin : g_sticky
      AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        $fell(errFlags[gi]) |-> $past(clrErr[gi])); // R14
    end
  endgenerate
endmodule

bind flash_err_seq flash_err_seq_chk u_chk (.*);

// File: tb/flash_err_seq_tb.sv
module flash_err_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [15:0] cmdAddr = 16'd0;
  logic        eccStrict = 1'b0, privOk = 1'b1, wpHit = 1'b0, wpForeign = 1'b0;
  logic        borReady = 1'b1, hotEvt = 1'b0, rstEvt = 1'b0, tamperEvt = 1'b0;
  logic        fifoUnder = 1'b0, busErr = 1'b0, fifoReady = 1'b0;
  logic [7:0]  cpwIn = 8'd3;
  logic        clrDone = 1'b0;
  logic [8:0]  clrErr = 9'd0;
  logic        busy, done, wrStrobe;
  logic [8:0]  errFlags;

  always #10 clk = ~clk;

  flash_err_seq u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .eccStrict(eccStrict), .privOk(privOk), .wpHit(wpHit), .wpForeign(wpForeign),
    .borReady(borReady), .hotEvt(hotEvt), .rstEvt(rstEvt), .tamperEvt(tamperEvt),
    .fifoUnder(fifoUnder), .busErr(busErr), .fifoReady(fifoReady), .cpwIn(cpwIn),
    .clrDone(clrDone), .clrErr(clrErr), .busy(busy), .done(done),
    .errFlags(errFlags), .wrStrobe(wrStrobe)
  );

  typedef struct {
    string      tag;
    logic [8:0] err;
    logic       dn;
    int         str;
    int         bsy;
    int         fall;
  } rec_t;

  rec_t expQ[$];
  rec_t actQ[$];
  int   nChecks = 0, nFails = 0;
  int   strCnt = 0, busyCnt = 0, fallCnt = 0;
  logic fallDoneV = 1'b0, prevBusy = 1'b0;
  bit   finished = 1'b0;

  always @(negedge clk) begin
    if (wrStrobe) strCnt++;
    if (busy) busyCnt++;
    if (prevBusy && !busy) begin
      fallDoneV = done;
      fallCnt++;
    end
    prevBusy = busy;
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as results are produced
  initial begin
    forever begin
      rec_t e, a;
      wait (actQ.size() != 0);
      a = actQ.pop_front();
      e = expQ.pop_front();
      check({e.tag, " flags"}, int'(a.err), int'(e.err));
      check({e.tag, " done"}, int'(a.dn), int'(e.dn));
      check({e.tag, " strobes"}, a.str, e.str);
      check({e.tag, " busy cycles"}, a.bsy, e.bsy);
      if (e.fall >= 0) check({e.tag, " done at busy fall"}, a.fall, e.fall);
    end
  end

  // evKind: 1 reset/low-voltage, 2 thermal, 3 tamper, 4 underrun, 5 bus error
  task automatic doCase(input string tag, input logic [2:0] op, input logic [15:0] addr,
                        input logic ecc, input logic priv, input logic wp, input logic wpf,
                        input logic bor, input logic hotAtCmd, input logic rstAtCmd,
                        input int cpw, input int fd, input int evKind, input int evAt,
                        input logic [8:0] eErr, input logic eDone, input int eStr,
                        input int eBusy, input int eFall);
    int s0, b0, f0;
    rec_t e, a;
    @(negedge clk);
    clrDone = 1'b1; clrErr = 9'h1FF;
    @(negedge clk);
    clrDone = 1'b0; clrErr = 9'h000;
    cmdOp = op; cmdAddr = addr; eccStrict = ecc; privOk = priv; wpHit = wp;
    wpForeign = wpf; borReady = bor; hotEvt = hotAtCmd; rstEvt = rstAtCmd;
    cpwIn = 8'(cpw); cmdValid = 1'b1;
    s0 = strCnt; b0 = busyCnt; f0 = fallCnt;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      cmdValid  = 1'b0;
      borReady  = 1'b1;
      fifoReady = (fd >= 0) && (k >= fd);
      rstEvt    = (evKind == 1) && (k == evAt);
      hotEvt    = (evKind == 2) && (k == evAt);
      tamperEvt = (evKind == 3) && (k == evAt);
      fifoUnder = (evKind == 4) && (k == evAt);
      busErr    = (evKind == 5) && (k == evAt);
    end
    fifoReady = 1'b0; rstEvt = 1'b0; hotEvt = 1'b0; tamperEvt = 1'b0;
    fifoUnder = 1'b0; busErr = 1'b0;
    e.tag = tag; e.err = eErr; e.dn = eDone; e.str = eStr; e.bsy = eBusy; e.fall = eFall;
    a.tag = tag; a.err = errFlags; a.dn = done; a.str = strCnt - s0; a.bsy = busyCnt - b0;
    a.fall = (fallCnt != f0) ? int'(fallDoneV) : -1;
    expQ.push_back(e);
    actQ.push_back(a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check("R14 reset busy", int'(busy), 0);
    check("R14 reset done", int'(done), 0);
    check("R14 reset flags", int'(errFlags), 0);
    check("R13 reset strobe", int'(wrStrobe), 0);

    // tag op addr ecc priv wp wpf bor hot rst cpw fd ev evAt eErr eDone eStr eBusy eFall
    doCase("R13 word ok",        3'd1, 16'h0100, 0,1,0,0,1,0,0, 3,-1,0,0, 9'h000,1,1,3,1);   // R1
    doCase("R13 row ok",         3'd2, 16'h0200, 0,1,0,0,1,0,0, 3, 1,0,0, 9'h000,1,4,14,1);  // R1
    doCase("R13 erase cpw0",     3'd3, 16'h0300, 0,1,0,0,1,0,0, 0,-1,0,0, 9'h000,1,1,1,1);
    doCase("R5 reserved code",   3'd5, 16'h0100, 0,1,0,0,1,0,0, 3,-1,0,0, 9'h020,1,0,0,-1);
    doCase("R6 addr range",      3'd1, 16'hA000, 0,1,0,0,1,0,0, 3,-1,0,0, 9'h010,1,0,0,-1);
    doCase("R6 privilege",       3'd3, 16'h0100, 0,0,0,0,1,0,0, 3,-1,0,0, 9'h010,1,0,0,-1);
    doCase("R7 ecc word",        3'd1, 16'h0100, 1,1,0,0,1,0,0, 3,-1,0,0, 9'h030,1,0,0,-1);

    // R14: flags persist, partial clear, done clear
    repeat (5) @(negedge clk);
    check("R14 flags held", int'(errFlags), 9'h030);
    clrErr = 9'h020;
    @(negedge clk) clrErr = 9'h000;
    check("R14 partial clear", int'(errFlags), 9'h010);
    check("R14 done held", int'(done), 1);
    clrDone = 1'b1;
    @(negedge clk) clrDone = 1'b0;
    check("R14 done cleared", int'(done), 0);
    // R14: set wins over same-cycle clear
    cmdOp = 3'd6; cmdValid = 1'b1; clrErr = 9'h020;
    @(negedge clk) begin cmdValid = 1'b0; clrErr = 9'h000; end
    check("R14 set beats clear", int'(errFlags[5]), 1);

    doCase("R7 ecc row allowed", 3'd2, 16'h0100, 1,1,0,0,1,0,0, 3, 0,0,0, 9'h000,1,4,13,1);
    doCase("R8 write protect",   3'd1, 16'h0100, 0,1,1,0,1,0,0, 3,-1,0,0, 9'h100,1,0,0,-1);
    doCase("R8 foreign protect", 3'd2, 16'h0100, 0,1,1,1,1,0,0, 3,-1,0,0, 9'h108,1,0,0,-1);
    doCase("R3 bor not ready",   3'd1, 16'h0100, 0,1,0,0,0,0,0, 3,-1,0,0, 9'h002,1,0,0,-1);
    doCase("R4 hot at request",  3'd1, 16'h0100, 0,1,0,0,1,1,0, 3,-1,0,0, 9'h004,1,0,0,-1);
    doCase("R9 bor beats op",    3'd6, 16'h0100, 0,1,1,0,0,0,0, 3,-1,0,0, 9'h002,1,0,0,-1);
    doCase("R9 op beats addr",   3'd7, 16'hA000, 0,1,0,0,1,0,0, 3,-1,0,0, 9'h020,1,0,0,-1);
    doCase("R9 addr beats wp",   3'd1, 16'hB000, 0,1,1,1,1,0,0, 3,-1,0,0, 9'h010,1,0,0,-1);
    doCase("R2 reset at request",3'd1, 16'h0100, 0,1,0,0,1,0,1, 3,-1,0,0, 9'h002,0,0,0,-1);
    doCase("R2 reset in run",    3'd1, 16'h0100, 0,1,0,0,1,0,0, 3,-1,1,0, 9'h003,0,0,1,0);
    doCase("R2 reset in arming", 3'd2, 16'h0100, 0,1,0,0,1,0,0, 3, 5,1,1, 9'h002,0,0,2,0);
    doCase("R10 bus err arming", 3'd2, 16'h0100, 0,1,0,0,1,0,0, 3, 5,5,0, 9'h0C0,1,0,1,1);
    doCase("R4 hot in arming",   3'd2, 16'h0100, 0,1,0,0,1,0,0, 3, 5,2,2, 9'h004,1,0,3,1);
    doCase("R11 row underrun",   3'd2, 16'h0100, 0,1,0,0,1,0,0, 3, 0,4,4, 9'h041,1,1,5,1);
    doCase("R11 row bus err",    3'd2, 16'h0100, 0,1,0,0,1,0,0, 3, 0,5,4, 9'h0C1,1,1,5,1);
    doCase("R11 word ignores underrun", 3'd1, 16'h0100, 0,1,0,0,1,0,0, 3,-1,4,0, 9'h000,1,1,3,1);
    doCase("R12 tamper in run",  3'd1, 16'h0100, 0,1,0,0,1,0,0, 3,-1,3,1, 9'h009,1,0,2,1);

    wait (actQ.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule